// File: doc/BRIEF.md
# LIN Status Flag Register

This block holds the status and interrupt flags of a LIN controller. The protocol engine sends it single-cycle event pulses. One pulse means a header has been sent. One means the first data byte of a response group has arrived. Six more pulses mark individual error detections. Each event sets a sticky flag that software reads and clears over a small register bus. An aggregate error bit is formed from the six error flags. Two interrupt request lines are gated by software enable bits.

Software can only clear flags, never set them: a write of 1 leaves a bit unchanged. Which flags may be cleared depends on the operating mode supplied by the controller. The aggregate error bit cannot be written at all. It drops only once every individual error flag has been cleared. The data-group flag never raises an interrupt.

Top module: `lin_stat_flags`

## Requirements
- R1: After the asynchronous active-low reset, every flag and enable bit reads 0 and both interrupt outputs are low.
- R2: Register map (read through `rd_addr`, combinational `rd_data`). Address 0 is status: bit 0 is header sent, bit 1 is data group received, bit 7 is the aggregate error, other bits are 0. Address 1 holds the error flags in bits 5:0. Address 2 holds the enables: bit 0 is the header interrupt enable, bit 1 is the error interrupt enable. Status bit 7 reads 1 exactly when at least one error flag is 1.
- R3: A pulse on `ev_hdr_done`, `ev_d1_rx` or `ev_err[i]` sets the matching flag at the next clock edge. The flag stays set until cleared. The data-group flag sets again for each new group after software has cleared it.
- R4: Writes to status and error flags only clear bits: a 0 in a bit position clears that flag, a 1 leaves it as it was.
- R5: Mode encoding: 00 idle, 01 LIN operation, 10 LIN wake-up, 11 UART. Header and data-group flags are cleared only in mode 01. Error flags are cleared only in modes 01 or 10. Writes in any other mode leave the flags unchanged.
- R6: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: `irq_hdr` is high for exactly one cycle each time (header flag AND header enable) goes from 0 to 1. This includes enabling while the flag is already set.
- R8: `irq_err` is high for one cycle when (aggregate error AND error enable) goes from 0 to 1. Extra errors while the aggregate is already set give no new pulse.
- R9: Setting the data-group flag never asserts any interrupt output.
- R10: The enable register is writable in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode of the controller |
| ev_hdr_done | input | 1 | Header transmission finished pulse |
| ev_d1_rx | input | 1 | First byte of a data group received pulse |
| ev_err | input | 6 | Individual error detection pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| irq_hdr | output | 1 | Header interrupt request pulse |
| irq_err | output | 1 | Error interrupt request pulse |

## Verification
The bench builds the block with its defaults: six error sources, an 8-bit data bus and a 2-bit address. At this size every error bit, the aggregate bit and both enable bits appear at fixed positions that the bench can predict by hand. Those defaults put within reach partial clears of the error field, writes in all four modes, and same-cycle set and clear collisions on both flag kinds. They also cover interrupt edges caused by an enable write rather than by an event.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_LIN  = 2'b01,
        MODE_WAKE = 2'b10,
        MODE_UART = 2'b11
    } lin_mode_e;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_ERRORS = 2'd1;
    localparam logic [1:0] ADDR_ENABLE = 2'd2;

    localparam int BIT_HDR    = 0;
    localparam int BIT_D1     = 1;
    localparam int BIT_HDR_IE = 0;
    localparam int BIT_ERR_IE = 1;
endpackage

// File: rtl/lin_flag_cell.sv
module lin_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_ok_i,
    input  logic wr_bit_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } cell_t;

    cell_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_ok_i && !wr_bit_i) s_d.flag = 1'b0;
        // hardware event has priority over a clearing write
        if (set_i) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_o = s_q.flag;
endmodule

// File: rtl/lin_irq_edge.sv
module lin_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);
    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_o = level_i & ~s_q.prev;
endmodule

// File: rtl/lin_rd_mux.sv
module lin_rd_mux #(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2,
    parameter int NUM_ERR = 6
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               hdr_i,
    input  logic               d1_i,
    input  logic               agg_i,
    input  logic [NUM_ERR-1:0] err_i,
    input  logic               hdr_ie_i,
    input  logic               err_ie_i,
    output logic [DATA_W-1:0]  data_o
);
    import lin_stat_pkg::*;

    localparam int AGG_POS = DATA_W - 1;

    always_comb begin
        data_o = '0;
        case (addr_i)
            ADDR_W'(ADDR_STATUS): begin
                data_o[BIT_HDR] = hdr_i;
                data_o[BIT_D1]  = d1_i;
                data_o[AGG_POS] = agg_i;
            end
            ADDR_W'(ADDR_ERRORS): data_o[NUM_ERR-1:0] = err_i;
            ADDR_W'(ADDR_ENABLE): begin
                data_o[BIT_HDR_IE] = hdr_ie_i;
                data_o[BIT_ERR_IE] = err_ie_i;
            end
            default: data_o = '0;
        endcase
    end
endmodule

// File: rtl/lin_stat_flags.sv
module lin_stat_flags #(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2,
    parameter int NUM_ERR = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic               ev_hdr_done,
    input  logic               ev_d1_rx,
    input  logic [NUM_ERR-1:0] ev_err,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_hdr,
    output logic               irq_err
);
    import lin_stat_pkg::*;

    typedef struct packed {
        logic hdr_ie;
        logic err_ie;
    } ien_t;

    ien_t ien_d, ien_q;

    lin_mode_e mode_e;
    logic      lin_op, err_clr_mode;
    logic      wr_status, wr_errors, wr_enable;
    logic      hdr_q, d1_q, agg_err;
    logic      hdr_ie_q, err_ie_q;
    logic [NUM_ERR-1:0] err_q;

    assign mode_e       = lin_mode_e'(mode);
    assign lin_op       = (mode_e == MODE_LIN);
    assign err_clr_mode = (mode_e == MODE_LIN) || (mode_e == MODE_WAKE);

    assign wr_status = wr_en && (wr_addr == ADDR_W'(ADDR_STATUS)) && lin_op;
    assign wr_errors = wr_en && (wr_addr == ADDR_W'(ADDR_ERRORS)) && err_clr_mode;
    assign wr_enable = wr_en && (wr_addr == ADDR_W'(ADDR_ENABLE));

    lin_flag_cell u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ev_hdr_done),
        .wr_ok_i  (wr_status),
        .wr_bit_i (wr_data[BIT_HDR]),
        .flag_o   (hdr_q)
    );

    lin_flag_cell u_d1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ev_d1_rx),
        .wr_ok_i  (wr_status),
        .wr_bit_i (wr_data[BIT_D1]),
        .flag_o   (d1_q)
    );

    for (genvar gi = 0; gi < NUM_ERR; gi++) begin : g_err
        lin_flag_cell u_err (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (ev_err[gi]),
            .wr_ok_i  (wr_errors),
            .wr_bit_i (wr_data[gi]),
            .flag_o   (err_q[gi])
        );
    end

    assign agg_err = |err_q;

    always_comb begin
        ien_d = ien_q;
        if (wr_enable) begin
            ien_d.hdr_ie = wr_data[BIT_HDR_IE];
            ien_d.err_ie = wr_data[BIT_ERR_IE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ien_q <= '0;
        else        ien_q <= ien_d;
    end

    assign hdr_ie_q = ien_q.hdr_ie;
    assign err_ie_q = ien_q.err_ie;

    lin_irq_edge u_irq_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (hdr_q & hdr_ie_q),
        .pulse_o (irq_hdr)
    );

    lin_irq_edge u_irq_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (agg_err & err_ie_q),
        .pulse_o (irq_err)
    );

    lin_rd_mux #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NUM_ERR (NUM_ERR)
    ) u_rd (
        .addr_i   (rd_addr),
        .hdr_i    (hdr_q),
        .d1_i     (d1_q),
        .agg_i    (agg_err),
        .err_i    (err_q),
        .hdr_ie_i (hdr_ie_q),
        .err_ie_i (err_ie_q),
        .data_o   (rd_data)
    );
endmodule

// File: rtl/lin_stat_flags_chk.sv
module lin_stat_flags_chk #(
    parameter int NUM_ERR = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode,
    input logic               ev_hdr_done,
    input logic               ev_d1_rx,
    input logic [NUM_ERR-1:0] ev_err,
    input logic               hdr_q,
    input logic               d1_q,
    input logic [NUM_ERR-1:0] err_q,
    input logic               agg_err,
    input logic               err_ie_q,
    input logic               irq_hdr,
    input logic               irq_err
);
    AST_ERR_EVENT_AGG: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err != '0) |=> agg_err); // R2
    AST_HDR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hdr_done |=> hdr_q); // R6
    AST_D1_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!d1_q && !ev_d1_rx) |=> !d1_q); // R4
    AST_HDR_HELD_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_q && mode != 2'b01) |=> hdr_q); // R5
    AST_ERR_HELD_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b11) |=> ((err_q & $past(err_q)) == $past(err_q))); // R5
    AST_IRQ_HDR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hdr |=> !irq_hdr); // R7
    AST_IRQ_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (agg_err && err_ie_q)); // R8
    AST_IRQ_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |=> !irq_err); // R8
endmodule

bind lin_stat_flags lin_stat_flags_chk #(.NUM_ERR(NUM_ERR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .ev_hdr_done (ev_hdr_done),
    .ev_d1_rx    (ev_d1_rx),
    .ev_err      (ev_err),
    .hdr_q       (hdr_q),
    .d1_q        (d1_q),
    .err_q       (err_q),
    .agg_err     (agg_err),
    .err_ie_q    (err_ie_q),
    .irq_hdr     (irq_hdr),
    .irq_err     (irq_err)
);

// File: tb/tb_lin_stat_flags.sv
module tb_lin_stat_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       ev_hdr_done = 1'b0;
    logic       ev_d1_rx = 1'b0;
    logic [5:0] ev_err = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_hdr, irq_err;

    always #5 clk = ~clk;

    lin_stat_flags dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .ev_hdr_done(ev_hdr_done), .ev_d1_rx(ev_d1_rx), .ev_err(ev_err),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_hdr(irq_hdr), .irq_err(irq_err)
    );

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    int    cyc = 0;

    // monitor: pops one expected item per falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {6'b0, irq_err, irq_hdr} : rd_data;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
            end
        end
    end

    task automatic chk_rd(input logic [1:0] a, input logic [7:0] e, input string r);
        item_t it;
        rd_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.req = r;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic chk_irq(input logic [1:0] e, input string r);
        item_t it;
        it.is_irq = 1'b1; it.exp = {6'b0, e}; it.req = r;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic h, input logic d1, input logic [5:0] e);
        @(posedge clk); #1;
        ev_hdr_done = h; ev_d1_rx = d1; ev_err = e;
        @(posedge clk); #1;
        ev_hdr_done = 1'b0; ev_d1_rx = 1'b0; ev_err = '0;
    endtask

    task automatic pulse_wr(input logic h, input logic [5:0] e, input logic [1:0] a);
        @(posedge clk); #1;
        ev_hdr_done = h; ev_err = e;
        wr_en = 1'b1; wr_addr = a; wr_data = 8'h00;
        @(posedge clk); #1;
        ev_hdr_done = 1'b0; ev_err = '0; wr_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_rd(2'd0, 8'h00, "R1 status");
        chk_rd(2'd1, 8'h00, "R1 errors");
        chk_rd(2'd2, 8'h00, "R1 enables");
        chk_irq(2'b00, "R1 irq");

        mode = 2'b01;
        wr(2'd2, 8'h03);
        chk_rd(2'd2, 8'h03, "R2 enable readback");
        pulse(1'b1, 1'b0, 6'h00);
        chk_irq(2'b01, "R7 header irq");
        @(posedge clk); #1;
        chk_irq(2'b00, "R7 header irq one cycle");
        chk_rd(2'd0, 8'h01, "R3 header flag");

        wr(2'd2, 8'h02);
        wr(2'd0, 8'h00);
        chk_rd(2'd0, 8'h00, "R5 clear in LIN mode");
        pulse(1'b1, 1'b0, 6'h00);
        chk_irq(2'b00, "R7 header irq gated");
        chk_rd(2'd0, 8'h01, "R3 header reset flag");
        wr(2'd0, 8'hFF);
        chk_rd(2'd0, 8'h01, "R4 write one keeps");

        pulse(1'b0, 1'b1, 6'h00);
        chk_irq(2'b00, "R9 data flag no irq");
        chk_rd(2'd0, 8'h03, "R3 data flag");

        mode = 2'b10;
        wr(2'd0, 8'h00);
        chk_rd(2'd0, 8'h03, "R5 wakeup ignores status clear");
        mode = 2'b01;
        wr(2'd0, 8'h00);
        chk_rd(2'd0, 8'h00, "R5 status cleared");
        pulse(1'b0, 1'b1, 6'h00);
        chk_rd(2'd0, 8'h02, "R3 next data group");
        wr(2'd0, 8'h00);

        pulse(1'b0, 1'b0, 6'h08);
        chk_irq(2'b10, "R8 error irq");
        chk_rd(2'd0, 8'h80, "R2 aggregate set");
        chk_rd(2'd1, 8'h08, "R3 error bit 3");
        pulse(1'b0, 1'b0, 6'h01);
        chk_irq(2'b00, "R8 no second error irq");
        chk_rd(2'd1, 8'h09, "R3 error bit 0");

        mode = 2'b10;
        wr(2'd1, 8'h01);
        chk_rd(2'd1, 8'h01, "R4 partial error clear");
        chk_rd(2'd0, 8'h80, "R2 aggregate held");
        wr(2'd1, 8'h00);
        chk_rd(2'd1, 8'h00, "R5 wakeup clears errors");
        chk_rd(2'd0, 8'h00, "R2 aggregate dropped");
        wr(2'd1, 8'h3F);
        chk_rd(2'd1, 8'h00, "R4 write ones no set");

        mode = 2'b11;
        pulse(1'b0, 1'b0, 6'h20);
        chk_irq(2'b10, "R8 error irq again");
        wr(2'd1, 8'h00);
        chk_rd(2'd1, 8'h20, "R5 UART ignores clear");
        mode = 2'b00;
        wr(2'd1, 8'h00);
        chk_rd(2'd1, 8'h20, "R5 idle ignores clear");
        wr(2'd2, 8'h03);
        chk_rd(2'd2, 8'h03, "R10 enable write in idle");
        mode = 2'b10;
        wr(2'd1, 8'h00);
        chk_rd(2'd1, 8'h00, "R5 cleared in wakeup");

        mode = 2'b01;
        pulse_wr(1'b1, 6'h00, 2'd0);
        chk_rd(2'd0, 8'h01, "R6 header set wins");
        pulse_wr(1'b0, 6'h04, 2'd1);
        chk_rd(2'd1, 8'h04, "R6 error set wins");
        wr(2'd1, 8'h00);

        wr(2'd2, 8'h02);
        chk_irq(2'b00, "R7 enable off");
        wr(2'd2, 8'h03);
        chk_irq(2'b01, "R7 enable edge irq");

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule